// File: doc/BRIEF.md
# Second-Chance Page Victim Selector

This block holds three status flags per page-table entry (present, modified and recently-used) for a parameterised number of entries. It picks the entry to evict with the second-chance clock scheme. A hand persists between requests and sweeps through the entries. It gives a recently-used entry one more chance by clearing its flag, and it evicts the first present entry whose flag is already clear. The result reports whether the evicted page must be written back before its frame is reused.

Memory-access events set the flags: every access marks the entry recently-used, and a write also marks it modified. Software can set or clear the present flag of any entry. A one-cycle request starts a sweep. The block then examines one entry per clock and ends with a one-cycle completion pulse carrying the chosen index, the write-back flag, or a flag saying that nothing could be evicted.

Top module: `pg_clock_victim`

## Requirements
- R1: After reset every entry has present, modified and recently-used clear, the hand points at entry 0, and scan_busy and scan_done are low.
- R2: scan_req sampled high while scan_busy is low starts a sweep, and scan_busy is high from the next cycle. The sweep examines one entry per clock. scan_done is high for exactly one cycle, the cycle after the deciding examination, and scan_busy is low in that cycle. A request made while scan_busy is high is ignored.
- R3: An access event (acc_en high) sets the recently-used flag of entry acc_idx. If acc_wr is also high, it sets the modified flag of that entry.
- R4: The hand visits entries in increasing index order and wraps from entry N_ENTRIES-1 to entry 0. It keeps its position between sweeps. After a victim is chosen, the next sweep starts at the entry after the victim.
- R5: When the hand reaches a present entry that is recently-used, it clears that flag and moves on to the next entry.
- R6: When the hand reaches a present entry that is not recently-used, that entry becomes the victim. victim_idx gives its index and victim_dirty gives its modified flag. Its present, modified and recently-used flags are all cleared.
- R7: Entries that are not present are passed over without change.
- R8: If 2*N_ENTRIES entries are examined without finding a victim, the sweep ends with scan_done and victim_none high and victim_dirty low. victim_none is low on a completion that found a victim.
- R9: An access to the entry under the hand in the cycle it is examined counts as a reference. The entry keeps its recently-used flag and is not chosen.
- R10: A software write (sw_we) loads sw_val into the present flag of entry sw_idx. It wins over the clearing by a victim selection in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access event valid |
| acc_idx | input | IDX_W | Entry touched by the access |
| acc_wr | input | 1 | Access is a write |
| sw_we | input | 1 | Software present-flag write |
| sw_idx | input | IDX_W | Entry written by software |
| sw_val | input | 1 | New present-flag value |
| scan_req | input | 1 | Start a victim sweep |
| scan_busy | output | 1 | Sweep in progress |
| scan_done | output | 1 | One-cycle completion pulse |
| victim_none | output | 1 | Sweep found no victim |
| victim_idx | output | IDX_W | Chosen entry |
| victim_dirty | output | 1 | Chosen entry needs write-back |

## Verification
The flags and the hand are hidden, so a corrupted flag or a misplaced hand shows at the ports only at the next completion. It appears as a wrong victim_idx, a wrong victim_dirty, or a completion that comes too early or too late, since the sweep length equals the number of entries examined. A stale recently-used flag therefore becomes visible within at most 2*N_ENTRIES cycles of the next request. The bench compares every port on every clock against a behavioural model and checks the sweep length of directed cases. These cases include a wrap, skipped entries, an access that collides with the hand, and a sweep with nothing present.

// File: rtl/pgv_pkg.sv
package pgv_pkg;
   typedef enum logic {
      SCAN_IDLE = 1'b0,
      SCAN_RUN  = 1'b1
   } scan_state_e;
endpackage

// File: rtl/pgv_status_bits.sv
module pgv_status_bits #(
   parameter int N_ENTRIES = 16,
   parameter int IDX_W     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_en,
   input  logic [IDX_W-1:0]     acc_idx,
   input  logic                 acc_wr,
   input  logic                 sw_we,
   input  logic [IDX_W-1:0]     sw_idx,
   input  logic                 sw_val,
   input  logic                 hclr_en,
   input  logic                 vclr_en,
   input  logic [IDX_W-1:0]     clr_idx,
   output logic [N_ENTRIES-1:0] vld,
   output logic [N_ENTRIES-1:0] dty,
   output logic [N_ENTRIES-1:0] rfb
);
   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
      logic acc_hit, sw_hit, clr_hit;
      logic v_q, d_q, r_q;

      assign acc_hit = acc_en && (acc_idx == IDX_W'(i));
      assign sw_hit  = sw_we && (sw_idx == IDX_W'(i));
      assign clr_hit = clr_idx == IDX_W'(i);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
            r_q <= 1'b0;
         end else begin
            // software load beats the victim clear
            if (sw_hit)
               v_q <= sw_val;
            else if (vclr_en && clr_hit)
               v_q <= 1'b0;
            // access sets beat the hand's clears
            if (acc_hit && acc_wr)
               d_q <= 1'b1;
            else if (vclr_en && clr_hit)
               d_q <= 1'b0;
            if (acc_hit)
               r_q <= 1'b1;
            else if ((vclr_en || hclr_en) && clr_hit)
               r_q <= 1'b0;
         end
      end

      assign vld[i] = v_q;
      assign dty[i] = d_q;
      assign rfb[i] = r_q;
   end
endmodule

// File: rtl/pgv_hand_fsm.sv
module pgv_hand_fsm
   import pgv_pkg::*;
#(
   parameter int N_ENTRIES = 16,
   parameter int IDX_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scan_req,
   input  logic             cur_v,
   input  logic             cur_r_eff,
   input  logic             cur_d,
   output logic [IDX_W-1:0] hand,
   output logic             busy,
   output logic             hclr_en,
   output logic             vclr_en,
   output logic             done,
   output logic             none,
   output logic [IDX_W-1:0] vidx,
   output logic             vdirty
);
   localparam int LIMIT = 2 * N_ENTRIES - 1;
   localparam int CNT_W = $clog2(2 * N_ENTRIES) + 1;

   scan_state_e      st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] hand_nxt;
   logic             hit, give_up;

   assign busy     = (st_q == SCAN_RUN);
   assign hit      = busy && cur_v && !cur_r_eff;
   assign hclr_en  = busy && cur_v && cur_r_eff;
   assign vclr_en  = hit;
   assign give_up  = busy && !hit && (cnt_q == CNT_W'(LIMIT));
   assign hand_nxt = (hand == IDX_W'(N_ENTRIES - 1)) ? '0 : hand + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SCAN_IDLE;
         cnt_q  <= '0;
         hand   <= '0;
         done   <= 1'b0;
         none   <= 1'b0;
         vidx   <= '0;
         vdirty <= 1'b0;
      end else begin
         done <= hit || give_up;
         none <= give_up;
         if (hit) begin
            vidx   <= hand;
            vdirty <= cur_d;
         end else if (give_up) begin
            vdirty <= 1'b0;
         end
         if (st_q == SCAN_IDLE) begin
            if (scan_req) begin
               st_q  <= SCAN_RUN;
               cnt_q <= '0;
            end
         end else begin
            hand  <= hand_nxt;
            cnt_q <= cnt_q + 1'b1;
            if (hit || give_up)
               st_q <= SCAN_IDLE;
         end
      end
   end
endmodule

// File: rtl/pg_clock_victim.sv
module pg_clock_victim #(
   parameter int N_ENTRIES = 16,
   parameter int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_en,
   input  logic [IDX_W-1:0] acc_idx,
   input  logic             acc_wr,
   input  logic             sw_we,
   input  logic [IDX_W-1:0] sw_idx,
   input  logic             sw_val,
   input  logic             scan_req,
   output logic             scan_busy,
   output logic             scan_done,
   output logic             victim_none,
   output logic [IDX_W-1:0] victim_idx,
   output logic             victim_dirty
);
   if (N_ENTRIES < 2) begin : g_bad_depth
      $error("pg_clock_victim: N_ENTRIES must be at least 2");
   end
   if ((1 << IDX_W) < N_ENTRIES) begin : g_bad_width
      $error("pg_clock_victim: IDX_W too narrow for N_ENTRIES");
   end

   logic [N_ENTRIES-1:0] vld, dty, rfb;
   logic [IDX_W-1:0]     hand;
   logic                 hclr_en, vclr_en;
   logic                 cur_v, cur_d, cur_r_eff;

   assign cur_v     = vld[hand];
   assign cur_d     = dty[hand];
   assign cur_r_eff = rfb[hand] || (acc_en && (acc_idx == hand));

   pgv_status_bits #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_bits (
      .clk(clk), .rst_n(rst_n),
      .acc_en(acc_en), .acc_idx(acc_idx), .acc_wr(acc_wr),
      .sw_we(sw_we), .sw_idx(sw_idx), .sw_val(sw_val),
      .hclr_en(hclr_en), .vclr_en(vclr_en), .clr_idx(hand),
      .vld(vld), .dty(dty), .rfb(rfb)
   );

   pgv_hand_fsm #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_hand (
      .clk(clk), .rst_n(rst_n), .scan_req(scan_req),
      .cur_v(cur_v), .cur_r_eff(cur_r_eff), .cur_d(cur_d),
      .hand(hand), .busy(scan_busy),
      .hclr_en(hclr_en), .vclr_en(vclr_en),
      .done(scan_done), .none(victim_none),
      .vidx(victim_idx), .vdirty(victim_dirty)
   );
endmodule

// File: rtl/pgv_checker.sv
module pgv_checker #(
   parameter int N_ENTRIES = 16,
   parameter int IDX_W     = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 scan_req,
   input logic                 scan_busy,
   input logic                 scan_done,
   input logic                 victim_none,
   input logic [IDX_W-1:0]     victim_idx,
   input logic                 victim_dirty,
   input logic [IDX_W-1:0]     hand,
   input logic [N_ENTRIES-1:0] vld,
   input logic [N_ENTRIES-1:0] dty,
   input logic [N_ENTRIES-1:0] rfb,
   input logic                 acc_en,
   input logic [IDX_W-1:0]     acc_idx,
   input logic                 acc_wr,
   input logic                 sw_we,
   input logic [IDX_W-1:0]     sw_idx
);
   logic [N_ENTRIES-1:0] vld_d, dty_d, rfb_d;
   logic [IDX_W-1:0]     acc_idx_d, sw_idx_d, hand_d, vnext;
   logic                 sw_we_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_d <= '0; dty_d <= '0; rfb_d <= '0;
         acc_idx_d <= '0; sw_idx_d <= '0; hand_d <= '0; sw_we_d <= 1'b0;
      end else begin
         vld_d <= vld; dty_d <= dty; rfb_d <= rfb;
         acc_idx_d <= acc_idx; sw_idx_d <= sw_idx; hand_d <= hand; sw_we_d <= sw_we;
      end
   end

   always_comb vnext = (victim_idx == IDX_W'(N_ENTRIES - 1)) ? '0 : victim_idx + 1'b1;

   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_busy && scan_req) |=> scan_busy);
   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> !scan_busy);
   // R6
   victim_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_done && !victim_none) |->
         (vld_d[victim_idx] && !rfb_d[victim_idx] && victim_dirty == dty_d[victim_idx]
          && hand_d == victim_idx));
   // R6
   victim_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_done && !victim_none && !(sw_we_d && sw_idx_d == victim_idx)) |->
         (!vld[victim_idx] && !dty[victim_idx] && !rfb[victim_idx]));
   // R4
   hand_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_done && !victim_none) |-> hand == vnext);
   // R3
   acc_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_en |=> rfb[acc_idx_d]);
   // R3
   acc_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_wr) |=> dty[acc_idx_d]);
   // R8
   none_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_done && victim_none) |-> !victim_dirty);
endmodule

bind pg_clock_victim pgv_checker #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_pgv_chk (
   .clk(clk), .rst_n(rst_n), .scan_req(scan_req), .scan_busy(scan_busy),
   .scan_done(scan_done), .victim_none(victim_none), .victim_idx(victim_idx),
   .victim_dirty(victim_dirty), .hand(hand), .vld(vld), .dty(dty), .rfb(rfb),
   .acc_en(acc_en), .acc_idx(acc_idx), .acc_wr(acc_wr),
   .sw_we(sw_we), .sw_idx(sw_idx)
);

// File: tb/tb_pg_clock_victim.sv
module tb_pg_clock_victim;
   localparam int N  = 16;
   localparam int IW = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n, acc_en, acc_wr, sw_we, sw_val, scan_req;
   logic [IW-1:0] acc_idx, sw_idx;
   logic          scan_busy, scan_done, victim_none, victim_dirty;
   logic [IW-1:0] victim_idx;

   pg_clock_victim #(.N_ENTRIES(N)) dut (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_idx(acc_idx), .acc_wr(acc_wr),
      .sw_we(sw_we), .sw_idx(sw_idx), .sw_val(sw_val), .scan_req(scan_req),
      .scan_busy(scan_busy), .scan_done(scan_done), .victim_none(victim_none),
      .victim_idx(victim_idx), .victim_dirty(victim_dirty)
   );

   int compared = 0, mismatched = 0;
   bit finished = 0;

   task automatic check(bit ok, string rq, int act, int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   // behavioural reference
   bit m_v[N], m_r[N], m_d[N];
   int m_hand, m_cnt, m_vidx, ci;
   bit m_busy, m_done, m_none, m_vd, dovc, dorc;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin m_v[i] = 0; m_r[i] = 0; m_d[i] = 0; end
         m_hand = 0; m_cnt = 0; m_vidx = 0; m_busy = 0; m_done = 0; m_none = 0; m_vd = 0;
      end else begin
         ci = m_hand; dovc = 0; dorc = 0; m_done = 0; m_none = 0;
         if (m_busy) begin
            if (m_v[ci] && !(m_r[ci] || (acc_en && int'(acc_idx) == ci))) begin
               dovc = 1; m_vidx = ci; m_vd = m_d[ci]; m_done = 1; m_busy = 0;
            end else begin
               if (m_v[ci]) dorc = 1;
               m_cnt++;
               if (m_cnt == 2 * N) begin m_done = 1; m_none = 1; m_vd = 0; m_busy = 0; end
            end
            m_hand = (m_hand + 1) % N;
         end else if (scan_req) begin
            m_busy = 1; m_cnt = 0;
         end
         if (dovc) begin m_v[ci] = 0; m_d[ci] = 0; m_r[ci] = 0; end
         if (dorc) m_r[ci] = 0;
         if (acc_en) begin m_r[acc_idx] = 1; if (acc_wr) m_d[acc_idx] = 1; end
         if (sw_we) m_v[sw_idx] = sw_val;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(scan_busy == m_busy, "R2 busy", scan_busy, m_busy);
         check(scan_done == m_done, "R2 done", scan_done, m_done);
         if (m_done) begin
            check(victim_none == m_none, "R8 none", victim_none, m_none);
            check(victim_dirty == m_vd, "R6/R3 dirty", victim_dirty, m_vd);
            if (!m_none)
               check(int'(victim_idx) == m_vidx, "R4/R5/R7/R9/R10 victim", victim_idx, m_vidx);
         end
      end
   end

   task automatic idle_inputs();
      acc_en = 0; acc_idx = '0; acc_wr = 0; sw_we = 0; sw_idx = '0; sw_val = 0; scan_req = 0;
   endtask

   task automatic sw_set(int idx, bit val);
      @(negedge clk); sw_we = 1; sw_idx = IW'(idx); sw_val = val;
      @(negedge clk); sw_we = 0;
   endtask

   task automatic access(int idx, bit wr);
      @(negedge clk); acc_en = 1; acc_idx = IW'(idx); acc_wr = wr;
      @(negedge clk); acc_en = 0; acc_wr = 0;
   endtask

   // sweep; optional access to 'hit_idx' during the first examined cycle
   task automatic sweep(bit col, int hit_idx, output int lat, output int idx,
                        output bit dirty, output bit none);
      @(negedge clk); scan_req = 1;
      @(negedge clk); scan_req = 0;
      if (col) begin acc_en = 1; acc_idx = IW'(hit_idx); acc_wr = 0; end
      lat = 0;
      while (1) begin
         @(negedge clk);
         acc_en = 0;
         lat++;
         if (scan_done || lat > 4 * N) break;
      end
      idx = victim_idx; dirty = victim_dirty; none = victim_none;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         mismatched++; compared++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      int lat, idx;
      bit dirty, none;
      idle_inputs();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(!scan_busy, "R1 busy after reset", scan_busy, 0);
      check(!scan_done, "R1 done after reset", scan_done, 0);

      // R8 / R1: nothing present after reset
      sweep(0, 0, lat, idx, dirty, none);
      check(none, "R8 none flag", none, 1);
      check(lat == 2 * N, "R8 sweep length", lat, 2 * N);
      check(!dirty, "R8 dirty low", dirty, 0);

      for (int i = 0; i < N; i++) sw_set(i, 1);
      sweep(0, 0, lat, idx, dirty, none);
      check(idx == 0 && !none, "R2/R6 first victim", idx, 0);
      check(lat == 1, "R2 one entry per cycle", lat, 1);
      sweep(0, 0, lat, idx, dirty, none);
      check(idx == 1, "R4 hand persists", idx, 1);

      access(2, 0);
      access(3, 1);
      sweep(0, 0, lat, idx, dirty, none);
      check(idx == 4, "R5 second chance victim", idx, 4);
      check(lat == 3, "R5/R3 sweep length", lat, 3);

      sw_set(5, 0);
      sweep(0, 0, lat, idx, dirty, none);
      check(idx == 6, "R7/R10 skip absent", idx, 6);
      check(lat == 2, "R7 sweep length", lat, 2);

      // only entry 3 present; hand at 7, wraps
      for (int i = 0; i < N; i++) sw_set(i, 0);
      sw_set(3, 1);
      sweep(0, 0, lat, idx, dirty, none);
      check(idx == 3, "R4 wrap victim", idx, 3);
      check(dirty, "R6/R3 write-back flag", dirty, 1);
      check(lat == ((3 - 7 + N) % N) + 1, "R4 wrap length", lat, ((3 - 7 + N) % N) + 1);

      // hand at 4; access collides with the hand
      for (int i = 0; i < N; i++) sw_set(i, 1);
      sweep(1, 4, lat, idx, dirty, none);
      check(idx == 5, "R9 collision victim", idx, 5);
      check(lat == 2, "R9 sweep length", lat, 2);

      // random traffic, model compared every cycle
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         acc_en   = ($urandom_range(0, 2) == 0);
         acc_idx  = IW'($urandom_range(0, N - 1));
         acc_wr   = $urandom_range(0, 1) == 1;
         sw_we    = ($urandom_range(0, 7) == 0);
         sw_idx   = IW'($urandom_range(0, N - 1));
         sw_val   = ($urandom_range(0, 4) != 0);
         scan_req = ($urandom_range(0, 3) == 0);
      end
      @(negedge clk);
      idle_inputs();
      repeat (3 * N) @(negedge clk);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule